// File: doc/BRIEF.md
# Cyclic High-Side Switch Controller

This block sequences a battery-side switched supply output that powers external loads, most often mechanical wake-up switches. Software picks one of four modes through a 2-bit field: the output is either held off, held on, or pulsed with one of two repetition periods. Pulsing keeps a permanently closed external switch from drawing current all the time. A wake-up input, fed by those externally powered switches, is read only while the output is on and the switches are powered. The read happens once per pulse, late in the on-window, after the supply has settled.

An overload indication from the current comparator turns the output off at once and keeps it off. It also drops the switch-healthy diagnosis flag and, if interrupts are enabled, raises an interrupt pulse. If the system is asleep when the overload hits, the block forces a wake-up and records a reset-source code, because the wake-up switches have lost their supply. Software re-arms the output by writing the mode field again. All timing counts a prescaled tick input, so one tick stands for one time quantum (32 µs with the default parameters).

Top module: `cyc_hs_switch`

## Requirements
- R1: After reset, and whenever mode 2'b00 (off) is active, sw_en_o is 0. After reset sw_ok_o is 1, irq_o, wake_o and force_wake_o are 0, and rst_src_o is 3'b000.
- R2: In mode 2'b01 (on), sw_en_o is 1 on every cycle while no overload is latched.
- R3: In mode 2'b10 (cyclic A), sw_en_o is 1 for ON_TICKS ticks (12) at the start of each PER_A ticks (500). The first on-window begins in the cycle after the mode write.
- R4: In mode 2'b11 (cyclic B), the on-window is the same ON_TICKS ticks, repeated every PER_B ticks (1000).
- R5: In cyclic modes the wake-up pin is read once per period, at tick SAMPLE_AT (10) of the on-window. Pin changes that revert before that point produce no wake-up.
- R6: wake_o pulses for one cycle only when a read differs from the previous read. The first read after a mode write only sets the reference and never pulses.
- R7: An overload while sw_en_o is 1 forces sw_en_o to 0 and sw_ok_o to 0 from the next cycle on. Both stay there until the next mode write.
- R8: On an overload trip, irq_o pulses for one cycle if irq_en_i is 1, and stays 0 if irq_en_i is 0.
- R9: An overload trip while sleep_i is 1 pulses force_wake_o for one cycle and sets rst_src_o to 3'b101. rst_src_o holds that value until the next mode write, which clears it to 3'b000. A trip while awake leaves both unchanged.
- R10: Any mode write clears the overload latch. Writing off restores sw_ok_o to 1 and leaves sw_en_o at 0.
- R11: An overload indication while sw_en_o is 0, for example in the off-phase of a cyclic mode, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled time quantum strobe |
| mode_i | input | 2 | Mode value: 00 off, 01 on, 10 cyclic A, 11 cyclic B |
| mode_wr_i | input | 1 | Strobe that loads mode_i and re-arms the switch |
| irq_en_i | input | 1 | Interrupt enable |
| sleep_i | input | 1 | System is in sleep mode |
| ovld_i | input | 1 | Overload indication from the current comparator |
| wake_pin_i | input | 1 | Wake-up input fed by the switched supply |
| sw_en_o | output | 1 | Switch drive |
| sw_ok_o | output | 1 | Switch-healthy diagnosis flag |
| irq_o | output | 1 | Overload interrupt pulse |
| wake_o | output | 1 | Wake-up detected pulse |
| force_wake_o | output | 1 | Forced wake-up pulse on an overload in sleep |
| rst_src_o | output | 3 | Reset-source code |

## Verification
The bench measures the on-time and the distance between rising edges in both cyclic modes. A design with the wrong window length or the wrong period choice shows up as a wrong high-cycle count or a wrong edge gap. It toggles the wake-up pin back and forth outside the on-window and checks that no wake-up comes out. A design that sampled continuously would report a spurious wake-up there. It checks that the first read after a mode write stays silent, which catches a design that compares against a stale reference. The overload cases cover a trip in sleep, a trip in the off-phase, interrupts disabled, and re-arming by writing off. A design that freed the latch on its own, or that enabled the output when off was written, would drive the switch when it should not.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    HS_OFF   = 2'b00,
    HS_ON    = 2'b01,
    HS_CYC_A = 2'b10,
    HS_CYC_B = 2'b11
  } hs_mode_e;

  localparam logic [2:0] RSRC_NONE    = 3'b000;
  localparam logic [2:0] RSRC_SW_LOST = 3'b101;
endpackage

// File: rtl/hs_cycle_timer.sv
module hs_cycle_timer
  import hs_pkg::*;
#(
  parameter int PER_A     = 500,
  parameter int PER_B     = 1000,
  parameter int ON_TICKS  = 12,
  parameter int SAMPLE_AT = 10
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     restart_i,
  input  hs_mode_e mode_i,
  output logic     window_o,
  output logic     sample_o
);
  localparam int CW = $clog2(PER_B + 1);
  localparam logic [CW-1:0] LAST_A = CW'(PER_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(PER_B - 1);
  localparam logic [CW-1:0] ON_C   = CW'(ON_TICKS);
  localparam logic [CW-1:0] SMP_C  = CW'(SAMPLE_AT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          cyclic;

  assign cyclic = mode_i[1];
  assign last   = (mode_i == HS_CYC_B) ? LAST_B : LAST_A;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !cyclic) cnt_q <= '0;
    else if (tick_i)             cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  assign window_o = cyclic && (cnt_q < ON_C);
  assign sample_o = cyclic && tick_i && !restart_i && (cnt_q == SMP_C);
endmodule

// File: rtl/hs_wake_sampler.sv
module hs_wake_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic sample_i,
  input  logic enable_i,
  input  logic pin_i,
  output logic wake_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic ref_q, ref_vld_q, wake_q;
  logic take;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  assign take = sample_i && enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q     <= 1'b0;
      ref_vld_q <= 1'b0;
      wake_q    <= 1'b0;
    end else if (restart_i) begin
      ref_vld_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      wake_q <= take && ref_vld_q && (sync_q[SYNC_STAGES-1] != ref_q);
      if (take) begin
        ref_q     <= sync_q[SYNC_STAGES-1];
        ref_vld_q <= 1'b1;
      end
    end
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/hs_fault_ctl.sv
module hs_fault_ctl
  import hs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rearm_i,
  input  logic       ovld_i,
  input  logic       drive_i,
  input  logic       irq_en_i,
  input  logic       sleep_i,
  output logic       latched_o,
  output logic       irq_o,
  output logic       force_wake_o,
  output logic [2:0] rst_src_o
);
  logic trip;
  logic latch_q, irq_q, fw_q;
  logic [2:0] src_q;

  // an overload only counts while the switch is actually driven
  assign trip = ovld_i && drive_i && !rearm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      irq_q   <= 1'b0;
      fw_q    <= 1'b0;
      src_q   <= RSRC_NONE;
    end else begin
      irq_q <= trip && irq_en_i;
      fw_q  <= trip && sleep_i;
      if (rearm_i) begin
        latch_q <= 1'b0;
        src_q   <= RSRC_NONE;
      end else if (trip) begin
        latch_q <= 1'b1;
        if (sleep_i) src_q <= RSRC_SW_LOST;
      end
    end
  end

  assign latched_o    = latch_q;
  assign irq_o        = irq_q;
  assign force_wake_o = fw_q;
  assign rst_src_o    = src_q;
endmodule

// File: rtl/cyc_hs_switch.sv
module cyc_hs_switch
  import hs_pkg::*;
#(
  parameter int PER_A       = 500,
  parameter int PER_B       = 1000,
  parameter int ON_TICKS    = 12,
  parameter int SAMPLE_AT   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic       mode_wr_i,
  input  logic       irq_en_i,
  input  logic       sleep_i,
  input  logic       ovld_i,
  input  logic       wake_pin_i,
  output logic       sw_en_o,
  output logic       sw_ok_o,
  output logic       irq_o,
  output logic       wake_o,
  output logic       force_wake_o,
  output logic [2:0] rst_src_o
);
  hs_mode_e mode_q;
  logic window, sample, latched, drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= HS_OFF;
    else if (mode_wr_i) mode_q <= hs_mode_e'(mode_i);
  end

  hs_cycle_timer #(
    .PER_A(PER_A), .PER_B(PER_B), .ON_TICKS(ON_TICKS), .SAMPLE_AT(SAMPLE_AT)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .restart_i(mode_wr_i),
    .mode_i(mode_q), .window_o(window), .sample_o(sample)
  );

  assign drive = !latched && ((mode_q == HS_ON) || window);

  hs_fault_ctl u_fault (
    .clk_i(clk_i), .rst_ni(rst_ni), .rearm_i(mode_wr_i), .ovld_i(ovld_i),
    .drive_i(drive), .irq_en_i(irq_en_i), .sleep_i(sleep_i),
    .latched_o(latched), .irq_o(irq_o), .force_wake_o(force_wake_o),
    .rst_src_o(rst_src_o)
  );

  hs_wake_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(mode_wr_i), .sample_i(sample),
    .enable_i(!latched), .pin_i(wake_pin_i), .wake_o(wake_o)
  );

  assign sw_en_o = drive;
  assign sw_ok_o = !latched;
endmodule

// File: rtl/cyc_hs_switch_chk.sv
module cyc_hs_switch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_wr_i,
  input logic       irq_en_i,
  input logic       sleep_i,
  input logic       ovld_i,
  input logic       sw_en_o,
  input logic       sw_ok_o,
  input logic       irq_o,
  input logic       wake_o,
  input logic       force_wake_o,
  input logic [2:0] rst_src_o
);
  a_r7_trip_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && ovld_i && !mode_wr_i) |=> (!sw_en_o && !sw_ok_o));

  a_r7_no_drive_when_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_ok_o |-> !sw_en_o);

  a_r7_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_ok_o && !mode_wr_i) |=> !sw_ok_o);

  a_r10_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> sw_ok_o);

  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(irq_en_i) && !sw_ok_o));

  a_r9_force_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_wake_o |-> ($past(sleep_i) && rst_src_o == 3'b101));

  a_r6_wake_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  a_r11_no_trip_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_ok_o && !sw_en_o) |=> sw_ok_o);
endmodule

bind cyc_hs_switch cyc_hs_switch_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_wr_i(mode_wr_i), .irq_en_i(irq_en_i),
  .sleep_i(sleep_i), .ovld_i(ovld_i), .sw_en_o(sw_en_o), .sw_ok_o(sw_ok_o),
  .irq_o(irq_o), .wake_o(wake_o), .force_wake_o(force_wake_o),
  .rst_src_o(rst_src_o)
);

// File: tb/tb_cyc_hs_switch.sv
`timescale 1ns/1ps
module tb_cyc_hs_switch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [1:0] mode = 2'b00;
  logic mode_wr = 1'b0, irq_en = 1'b0, sleep = 1'b0, ovld = 1'b0, pin = 1'b0;
  logic sw_en, sw_ok, irq, wake, fwake;
  logic [2:0] rsrc;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cyc_hs_switch dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode), .mode_wr_i(mode_wr),
    .irq_en_i(irq_en), .sleep_i(sleep), .ovld_i(ovld), .wake_pin_i(pin),
    .sw_en_o(sw_en), .sw_ok_o(sw_ok), .irq_o(irq), .wake_o(wake),
    .force_wake_o(fwake), .rst_src_o(rsrc)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [1:0] m);
    mode = m; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic pulse_ovld();
    ovld = 1'b1;
    @(negedge clk);
    ovld = 1'b0;
  endtask

  task automatic observe(input int n, output int hi, output int rises,
                         output int first_r, output int last_r,
                         output int wk, output int first_wk);
    logic prev = 1'b0;
    hi = 0; rises = 0; first_r = -1; last_r = -1; wk = 0; first_wk = -1;
    for (int i = 0; i < n; i++) begin
      if (sw_en) hi++;
      if (sw_en && !prev) begin
        rises++;
        if (first_r < 0) first_r = i;
        last_r = i;
      end
      prev = sw_en;
      if (wake) begin
        wk++;
        if (first_wk < 0) first_wk = i;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 reset sw_en", sw_en, 0);
    check("R1 reset sw_ok", sw_ok, 1);
    check("R1 reset irq", irq, 0);
    check("R1 reset wake", wake, 0);
    check("R1 reset force_wake", fwake, 0);
    check("R1 reset rst_src", rsrc, 0);
  endtask

  task automatic t_off_on();
    int hi, r, fr, lr, wk, fw;
    wr_mode(2'b00);
    observe(300, hi, r, fr, lr, wk, fw);
    check("R1 off high cycles", hi, 0);
    wr_mode(2'b01);
    observe(1500, hi, r, fr, lr, wk, fw);
    check("R2 on high cycles", hi, 1500);
  endtask

  task automatic t_cyc_a();
    int hi, r, fr, lr, wk, fw;
    wr_mode(2'b10);
    observe(1000, hi, r, fr, lr, wk, fw);
    check("R3 A high cycles", hi, 24);
    check("R3 A rises", r, 2);
    check("R3 A first rise", fr, 0);
    check("R3 A period", lr - fr, 500);
  endtask

  task automatic t_cyc_b();
    int hi, r, fr, lr, wk, fw;
    wr_mode(2'b11);
    observe(2000, hi, r, fr, lr, wk, fw);
    check("R4 B high cycles", hi, 24);
    check("R4 B rises", r, 2);
    check("R4 B period", lr - fr, 1000);
  endtask

  task automatic t_wake();
    int hi, r, fr, lr, wk, fw;
    pin = 1'b0;
    wr_mode(2'b10);
    observe(100, hi, r, fr, lr, wk, fw);         // phase 0..99
    check("R6 first read silent", wk, 0);
    pin = 1'b1;
    observe(450, hi, r, fr, lr, wk, fw);         // phase 100..49
    check("R6 change reported", wk, 1);
    check("R5 read point", fw, 411);
    pin = 1'b0;
    observe(100, hi, r, fr, lr, wk, fw);         // phase 50..149
    pin = 1'b1;
    observe(400, hi, r, fr, lr, wk, fw);         // phase 150..49
    check("R5 glitch outside window ignored", wk, 0);
    observe(500, hi, r, fr, lr, wk, fw);
    check("R6 steady level silent", wk, 0);
    pin = 1'b0;
    observe(500, hi, r, fr, lr, wk, fw);
    check("R6 falling change reported", wk, 1);
  endtask

  task automatic t_ovld_sleep();
    int hi, r, fr, lr, wk, fw;
    sleep = 1'b1; irq_en = 1'b1;
    wr_mode(2'b01);
    pulse_ovld();
    check("R7 trip sw_en", sw_en, 0);
    check("R7 trip sw_ok", sw_ok, 0);
    check("R8 irq pulse", irq, 1);
    check("R9 force wake", fwake, 1);
    check("R9 rst_src", rsrc, 5);
    @(negedge clk);
    check("R8 irq one cycle", irq, 0);
    check("R9 force wake one cycle", fwake, 0);
    check("R9 rst_src held", rsrc, 5);
    observe(600, hi, r, fr, lr, wk, fw);
    check("R7 stays off", hi, 0);
    wr_mode(2'b00);
    check("R10 off rearm sw_ok", sw_ok, 1);
    check("R10 off rearm sw_en", sw_en, 0);
    check("R9 rst_src cleared by write", rsrc, 0);
    observe(50, hi, r, fr, lr, wk, fw);
    check("R10 off stays off", hi, 0);
    sleep = 1'b0;
    wr_mode(2'b01);
    check("R10 on after rearm", sw_en, 1);
  endtask

  task automatic t_ovld_awake();
    int hi, r, fr, lr, wk, fw;
    irq_en = 1'b0; sleep = 1'b0;
    wr_mode(2'b10);
    pulse_ovld();
    check("R7 cyclic trip sw_ok", sw_ok, 0);
    check("R8 irq masked", irq, 0);
    check("R9 awake no force wake", fwake, 0);
    check("R9 awake rst_src", rsrc, 0);
    observe(600, hi, r, fr, lr, wk, fw);
    check("R7 cyclic stays off", hi, 0);
    wr_mode(2'b10);
    observe(500, hi, r, fr, lr, wk, fw);
    check("R10 cyclic rearm", hi, 12);
  endtask

  task automatic t_ovld_idle();
    int hi, r, fr, lr, wk, fw;
    irq_en = 1'b1;
    wr_mode(2'b10);
    observe(100, hi, r, fr, lr, wk, fw);
    pulse_ovld();                                // phase 100, output off
    check("R11 idle overload sw_ok", sw_ok, 1);
    check("R11 idle overload irq", irq, 0);
    observe(399, hi, r, fr, lr, wk, fw);
    observe(500, hi, r, fr, lr, wk, fw);
    check("R11 cycling continues", hi, 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off_on();
    t_cyc_a();
    t_cyc_b();
    t_wake();
    t_ovld_sleep();
    t_ovld_awake();
    t_ovld_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule